// File: doc/BRIEF.md
# Two-Class Memory Request Bank Scheduler

This block sits between the request sources of a shared external memory and the controller that drives the memory device. Two request classes arrive on separate ports. The low-latency port serves a processor. The standard port serves streaming datapaths. Every request covers one full burst of 8 words. The block splits each logical address into bank, row and column fields. It files each request into a small queue for its class and bank. It then offers one request at a time to the downstream access controller.

The issue choice follows a fixed order of tests. A bank that the access controller reports busy is never chosen. A low-latency request wins over a standard one, but only while a sliding-window limiter still has credit. Within the winning class, a request in the current transfer direction is preferred, so reads and writes are grouped into runs. Once a run reaches its maximum length, the opposite direction is preferred. Ties are broken by rotating priority, starting at the bank after the last one issued.

Back-pressure rules. Both request ports are valid/ready. A request is taken on a clock edge where valid and ready are both high. Ready is never high while valid is low, so ready may depend on valid and on the address. The issue port is also valid/ready, and a request leaves its queue on an edge where iss_valid and iss_ready are both high. The offered request is chosen afresh every cycle, so its contents may change while iss_ready is low. The access controller takes whatever is on offer in the cycle it raises iss_ready.

Top module: `sdram_req_sched`

## Requirements
- R1: The address fields map as follows. The bank is addr[4:3]. iss_col is {addr[4+COL_W:5], addr[2:0]}, which is the column of the burst followed by its start word. iss_row is the address bits above bit 4+COL_W.
- R2: The request stage takes at most one request, on either port, in any two consecutive cycles. When both ports could be served, the grant alternates between them, and the low-latency port goes first after reset.
- R3: A port's ready stays low while the queue for its class and its request's bank holds QDEPTH entries. No request is lost while it waits.
- R4: If any low-latency request is at the head of a queue for a bank that is not busy, and the limiter has credit, the issued request is a low-latency one (iss_ll=1).
- R5: At most LL_MAX low-latency requests are issued in any LL_WIN consecutive cycles. A request that is held back by this limit is later issued with iss_ll=1 and is never issued as standard.
- R6: A bank whose bank_busy bit is 1 is never issued. If only busy banks hold requests, iss_valid is 0.
- R7: Within the chosen class, a request in the direction of the last issued request is preferred (iss_write 0 means read, 1 means write).
- R8: After RUN_MAX consecutive issues in one direction, a request in the opposite direction is preferred whenever one is eligible.
- R9: Among equally preferred candidates, the scan starts at the bank after the last one issued and wraps around.
- R10: After reset, iss_valid, ll_ready and st_ready are 0. The first issue prefers reads and scans from bank 0.
- R11: Requests of one class to one bank are issued in their arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ll_valid | input | 1 | Low-latency request present |
| ll_ready | output | 1 | Low-latency request taken |
| ll_addr | input | ADDR_W | Low-latency logical address |
| ll_write | input | 1 | Low-latency direction, 1 means write |
| st_valid | input | 1 | Standard request present |
| st_ready | output | 1 | Standard request taken |
| st_addr | input | ADDR_W | Standard logical address |
| st_write | input | 1 | Standard direction, 1 means write |
| bank_busy | input | 2**BANK_BITS | Per-bank busy flags from the access controller |
| iss_valid | output | 1 | A request is on offer |
| iss_ready | input | 1 | The access controller takes the offer |
| iss_bank | output | BANK_BITS | Bank of the offer |
| iss_row | output | ADDR_W-BANK_BITS-COL_W-3 | Row of the offer |
| iss_col | output | COL_W+3 | Column and burst start word of the offer |
| iss_write | output | 1 | Direction of the offer |
| iss_ll | output | 1 | The offer belongs to the low-latency class |

## Verification
A corrupted direction register or run counter shows up within one issue as a change in the read/write grouping order. A wrong last-bank pointer shows up in the next tie between banks as a rotated issue order. A limiter count that drifts by one moves the release of a held low-latency request to a cycle other than the eighth after the burst began, and the bench measures that cycle exactly. A queue pointer fault shows up on the second entry of a bank as a reordered or repeated row.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;
  localparam int WORD_BITS = 3;
endpackage

// File: rtl/req_fifo.sv
module req_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  assign dout  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full) else $error("queue written while full");
  assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty) else $error("queue read while empty");
endmodule

// File: rtl/ll_window_limit.sv
module ll_window_limit #(
  parameter int LL_MAX = 2,
  parameter int LL_WIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic allow
);
  // History covers the LL_WIN-1 cycles before the current one (LL_WIN >= 3).
  localparam int HW = LL_WIN - 1;
  localparam int CW = $clog2(LL_WIN + 1);

  logic [HW-1:0] hist;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      cnt  <= '0;
    end else begin
      hist <= {hist[HW-2:0], take};
      cnt  <= cnt + CW'(take) - CW'(hist[HW-1]);
    end
  end

  assign allow = (cnt < CW'(LL_MAX));

  assert_window_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (cnt < CW'(LL_MAX))) else $error("low-latency issue beyond window credit");
endmodule

// File: rtl/bank_stage.sv
module bank_stage
  import sched_pkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int RUN_MAX   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [(1<<BANK_BITS)-1:0]   ll_ne,
  input  logic [(1<<BANK_BITS)-1:0]   ll_wr,
  input  logic [(1<<BANK_BITS)-1:0]   st_ne,
  input  logic [(1<<BANK_BITS)-1:0]   st_wr,
  input  logic [(1<<BANK_BITS)-1:0]   busy,
  input  logic                        ll_allow,
  input  logic                        fire,
  output logic                        pick_valid,
  output logic [BANK_BITS-1:0]        pick_bank,
  output logic                        pick_ll
);
  localparam int NB = 1 << BANK_BITS;
  localparam int RW = $clog2(RUN_MAX + 1);

  dir_e                 cur_dir;
  logic [RW-1:0]        run_cnt;
  logic [BANK_BITS-1:0] last_bank;

  logic [NB-1:0] ll_elig, st_elig, elig, wr_v, match, cand;
  logic          use_ll, want_wr, pick_wr, found;

  always_comb begin
    ll_elig = ll_ne & ~busy & {NB{ll_allow}};
    st_elig = st_ne & ~busy;
    use_ll  = |ll_elig;
    elig    = use_ll ? ll_elig : st_elig;
    wr_v    = use_ll ? ll_wr : st_wr;
    want_wr = (run_cnt == RW'(RUN_MAX)) ? (cur_dir == DIR_RD) : (cur_dir == DIR_WR);
    match   = elig & (want_wr ? wr_v : ~wr_v);
    cand    = (|match) ? match : elig;
  end

  // Rotating scan: last_bank+1 first, last_bank itself last.
  always_comb begin
    pick_bank = '0;
    found     = 1'b0;
    for (int i = 1; i <= NB; i++) begin
      logic [BANK_BITS-1:0] idx;
      idx = last_bank + BANK_BITS'(i);
      if (!found && cand[idx]) begin
        found     = 1'b1;
        pick_bank = idx;
      end
    end
  end

  assign pick_valid = found;
  assign pick_ll    = use_ll;
  assign pick_wr    = wr_v[pick_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_dir   <= DIR_RD;
      run_cnt   <= '0;
      last_bank <= '1;
    end else if (fire) begin
      last_bank <= pick_bank;
      if (pick_wr == (cur_dir == DIR_WR)) begin
        if (run_cnt != RW'(RUN_MAX)) run_cnt <= run_cnt + 1'b1;
      end else begin
        cur_dir <= pick_wr ? DIR_WR : DIR_RD;
        run_cnt <= RW'(1);
      end
    end
  end

  assert_skip_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> !busy[pick_bank]) else $error("busy bank offered");
endmodule

// File: rtl/sdram_req_sched.sv
module sdram_req_sched
  import sched_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BANK_BITS = 2,
  parameter int COL_W     = 5,
  parameter int QDEPTH    = 2,
  parameter int LL_MAX    = 2,
  parameter int LL_WIN    = 8,
  parameter int RUN_MAX   = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 ll_valid,
  output logic                                 ll_ready,
  input  logic [ADDR_W-1:0]                    ll_addr,
  input  logic                                 ll_write,
  input  logic                                 st_valid,
  output logic                                 st_ready,
  input  logic [ADDR_W-1:0]                    st_addr,
  input  logic                                 st_write,
  input  logic [(1<<BANK_BITS)-1:0]            bank_busy,
  output logic                                 iss_valid,
  input  logic                                 iss_ready,
  output logic [BANK_BITS-1:0]                 iss_bank,
  output logic [ADDR_W-BANK_BITS-COL_W-4:0]    iss_row,
  output logic [COL_W+2:0]                     iss_col,
  output logic                                 iss_write,
  output logic                                 iss_ll
);
  localparam int NB    = 1 << BANK_BITS;
  localparam int ROW_W = ADDR_W - WORD_BITS - BANK_BITS - COL_W;
  localparam int CO_W  = COL_W + WORD_BITS;
  localparam int EW    = 1 + ROW_W + CO_W;

  // ---- address split ----
  logic [BANK_BITS-1:0] ll_bank, st_bank;
  logic [EW-1:0]        ll_ent, st_ent;

  assign ll_bank = ll_addr[WORD_BITS +: BANK_BITS];
  assign st_bank = st_addr[WORD_BITS +: BANK_BITS];
  assign ll_ent  = {ll_write, ll_addr[ADDR_W-1 -: ROW_W],
                    ll_addr[WORD_BITS+BANK_BITS +: COL_W], ll_addr[WORD_BITS-1:0]};
  assign st_ent  = {st_write, st_addr[ADDR_W-1 -: ROW_W],
                    st_addr[WORD_BITS+BANK_BITS +: COL_W], st_addr[WORD_BITS-1:0]};

  // ---- per-class, per-bank queues (class 0 = low latency, 1 = standard) ----
  logic [NB-1:0] q_push [2];
  logic [NB-1:0] q_pop  [2];
  logic [NB-1:0] q_full [2];
  logic [NB-1:0] q_empty[2];
  logic [EW-1:0] q_dout [2][NB];

  for (genvar c = 0; c < 2; c++) begin : g_cls
    for (genvar b = 0; b < NB; b++) begin : g_bank
      req_fifo #(.W(EW), .DEPTH(QDEPTH)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push[c][b]),
        .pop   (q_pop[c][b]),
        .din   ((c == 0) ? ll_ent : st_ent),
        .dout  (q_dout[c][b]),
        .empty (q_empty[c][b]),
        .full  (q_full[c][b])
      );
    end
  end

  // ---- request stage: one transfer per two cycles, alternating ports ----
  logic rs_cool, rs_pref_st, can_ll, can_st, ll_take_in, st_take_in;

  assign can_ll     = ll_valid && !rs_cool && !q_full[0][ll_bank];
  assign can_st     = st_valid && !rs_cool && !q_full[1][st_bank];
  assign ll_ready   = can_ll && (!can_st || !rs_pref_st);
  assign st_ready   = can_st && (!can_ll || rs_pref_st);
  assign ll_take_in = ll_valid && ll_ready;
  assign st_take_in = st_valid && st_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_cool    <= 1'b0;
      rs_pref_st <= 1'b0;
    end else begin
      rs_cool <= ll_take_in || st_take_in;
      if (ll_take_in)      rs_pref_st <= 1'b1;
      else if (st_take_in) rs_pref_st <= 1'b0;
    end
  end

  always_comb begin
    q_push[0] = '0;
    q_push[1] = '0;
    q_push[0][ll_bank] = ll_take_in;
    q_push[1][st_bank] = st_take_in;
  end

  // ---- bank stage ----
  logic [NB-1:0]        ll_ne, st_ne, ll_wr_v, st_wr_v;
  logic                 ll_allow, pick_valid, pick_ll, fire;
  logic [BANK_BITS-1:0] pick_bank;
  logic [EW-1:0]        sel;

  assign ll_ne = ~q_empty[0];
  assign st_ne = ~q_empty[1];

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      ll_wr_v[b] = q_dout[0][b][EW-1];
      st_wr_v[b] = q_dout[1][b][EW-1];
    end
  end

  bank_stage #(.BANK_BITS(BANK_BITS), .RUN_MAX(RUN_MAX)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .ll_ne      (ll_ne),
    .ll_wr      (ll_wr_v),
    .st_ne      (st_ne),
    .st_wr      (st_wr_v),
    .busy       (bank_busy),
    .ll_allow   (ll_allow),
    .fire       (fire),
    .pick_valid (pick_valid),
    .pick_bank  (pick_bank),
    .pick_ll    (pick_ll)
  );

  ll_window_limit #(.LL_MAX(LL_MAX), .LL_WIN(LL_WIN)) u_limit (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (fire && pick_ll),
    .allow (ll_allow)
  );

  assign fire = pick_valid && iss_ready;

  always_comb begin
    q_pop[0] = '0;
    q_pop[1] = '0;
    if (fire) begin
      if (pick_ll) q_pop[0][pick_bank] = 1'b1;
      else         q_pop[1][pick_bank] = 1'b1;
    end
  end

  assign sel       = pick_ll ? q_dout[0][pick_bank] : q_dout[1][pick_bank];
  assign iss_valid = pick_valid;
  assign iss_bank  = pick_bank;
  assign iss_ll    = pick_ll;
  assign iss_write = sel[EW-1];
  assign iss_row   = sel[EW-2 -: ROW_W];
  assign iss_col   = sel[CO_W-1:0];

  assert_req_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_take_in || st_take_in) |=> !(ll_take_in || st_take_in))
    else $error("two request transfers in consecutive cycles");
  assert_ll_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ll) |-> (!ll_allow || ((~q_empty[0] & ~bank_busy) == '0)))
    else $error("standard request offered over an eligible low-latency one");
endmodule

// File: tb/test_sdram_req_sched.sv
`timescale 1ns/1ps
module test_sdram_req_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ll_valid = 0, ll_write = 0, st_valid = 0, st_write = 0, iss_ready = 0;
  logic [15:0] ll_addr = '0, st_addr = '0;
  logic [3:0]  bank_busy = '0;
  logic        ll_ready, st_ready, iss_valid, iss_write, iss_ll;
  logic [1:0]  iss_bank;
  logic [5:0]  iss_row;
  logic [7:0]  iss_col;

  sdram_req_sched i_sdram_req_sched (
    .clk(clk), .rst_n(rst_n),
    .ll_valid(ll_valid), .ll_ready(ll_ready), .ll_addr(ll_addr), .ll_write(ll_write),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_write(st_write),
    .bank_busy(bank_busy),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_bank(iss_bank), .iss_row(iss_row),
    .iss_col(iss_col), .iss_write(iss_write), .iss_ll(iss_ll)
  );

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  logic [17:0] exp_q[$];
  string       tag_q[$];
  int          ll_cyc[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] mk_addr(logic [5:0] row, logic [4:0] colf, logic [1:0] bank, logic [2:0] word);
    return {row, colf, bank, word};
  endfunction

  task automatic expect_issue(bit ll, bit wr, logic [1:0] bank, logic [5:0] row, logic [4:0] colf,
                              logic [2:0] word, string tag);
    exp_q.push_back({ll, wr, bank, row, colf, word});
    tag_q.push_back(tag);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && iss_valid && iss_ready) begin
      logic [17:0] act, e;
      string t;
      act = {iss_ll, iss_write, iss_bank, iss_row, iss_col};
      if (iss_ll) ll_cyc.push_back(cyc);
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R11 unexpected issue actual=%h expected=none", act);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", t, act, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 0; ll_valid = 0; st_valid = 0; iss_ready = 0; bank_busy = '0;
    repeat (3) step();
    rst_n = 1;
    ll_cyc.delete();
  endtask

  task automatic send(bit is_ll, logic [15:0] a, bit wr);
    int n = 0;
    if (is_ll) begin ll_valid = 1; ll_addr = a; ll_write = wr; end
    else       begin st_valid = 1; st_addr = a; st_write = wr; end
    forever begin
      @(negedge clk);
      if (is_ll ? ll_ready : st_ready) begin
        step();
        break;
      end
      n++;
      if (n > 50) begin
        check(0, "R2 request never taken", 0, 1);
        step();
        break;
      end
    end
    if (is_ll) ll_valid = 0; else st_valid = 0;
  endtask

  task automatic drain();
    int n = 0;
    iss_ready = 1;
    while (exp_q.size() != 0 && n < 200) begin
      step();
      n++;
    end
    step();
    iss_ready = 0;
    check(exp_q.size() == 0, "R11 expected issues missing", exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    do_reset();
    // R10: reset state
    @(negedge clk);
    check(iss_valid == 0, "R10 iss_valid after reset", iss_valid, 0);
    check(ll_ready == 0 && st_ready == 0, "R10 readies after reset", {ll_ready, st_ready}, 0);
    step();

    // R1 / R9 / R10: reads to all banks, issued in rotation from bank 0
    send(0, mk_addr(6'h11, 5'h03, 2'd2, 3'd5), 0);
    send(0, mk_addr(6'h2a, 5'h1f, 2'd0, 3'd1), 0);
    send(0, mk_addr(6'h05, 5'h10, 2'd3, 3'd7), 0);
    send(0, mk_addr(6'h3f, 5'h00, 2'd1, 3'd0), 0);
    @(negedge clk);
    check(iss_valid == 1, "R10 offer present while iss_ready low", iss_valid, 1);
    step();
    expect_issue(0, 0, 2'd0, 6'h2a, 5'h1f, 3'd1, "R1 R9 R10 bank0 first");
    expect_issue(0, 0, 2'd1, 6'h3f, 5'h00, 3'd0, "R1 R9 bank1");
    expect_issue(0, 0, 2'd2, 6'h11, 5'h03, 3'd5, "R1 R9 bank2");
    expect_issue(0, 0, 2'd3, 6'h05, 5'h10, 3'd7, "R1 R9 bank3");
    drain();

    // R3 / R11: full queue back-pressure, order kept
    do_reset();
    send(0, mk_addr(6'd1, 5'd2, 2'd0, 3'd0), 0);
    send(0, mk_addr(6'd2, 5'd2, 2'd0, 3'd0), 0);
    st_valid = 1; st_addr = mk_addr(6'd3, 5'd2, 2'd0, 3'd0); st_write = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(st_ready == 0, "R3 ready low on full queue", st_ready, 0);
      step();
    end
    st_valid = 0;
    expect_issue(0, 0, 2'd0, 6'd1, 5'd2, 3'd0, "R11 first of bank0");
    expect_issue(0, 0, 2'd0, 6'd2, 5'd2, 3'd0, "R11 second of bank0");
    drain();

    // R2: both ports busy, alternation and spacing
    do_reset();
    ll_valid = 1; ll_addr = mk_addr(6'd7, 5'd1, 2'd1, 3'd0); ll_write = 0;
    st_valid = 1; st_addr = mk_addr(6'd8, 5'd1, 2'd0, 3'd0); st_write = 0;
    @(negedge clk);
    check(ll_ready == 1 && st_ready == 0, "R2 low-latency port first", {ll_ready, st_ready}, 2);
    step();
    ll_addr = mk_addr(6'd9, 5'd1, 2'd2, 3'd0);
    @(negedge clk);
    check(ll_ready == 0 && st_ready == 0, "R2 idle cycle after transfer", {ll_ready, st_ready}, 0);
    step();
    @(negedge clk);
    check(ll_ready == 0 && st_ready == 1, "R2 standard port next", {ll_ready, st_ready}, 1);
    step();
    st_valid = 0;
    @(negedge clk);
    check(ll_ready == 0, "R2 idle cycle after second transfer", ll_ready, 0);
    step();
    @(negedge clk);
    check(ll_ready == 1, "R2 low-latency port again", ll_ready, 1);
    step();
    ll_valid = 0;
    expect_issue(1, 0, 2'd1, 6'd7, 5'd1, 3'd0, "R2 R4 ll bank1");
    expect_issue(1, 0, 2'd2, 6'd9, 5'd1, 3'd0, "R2 R4 ll bank2");
    expect_issue(0, 0, 2'd0, 6'd8, 5'd1, 3'd0, "R2 st bank0");
    drain();

    // R4: low-latency preferred over earlier standard requests
    do_reset();
    send(0, mk_addr(6'd1, 5'd0, 2'd0, 3'd0), 0);
    send(0, mk_addr(6'd2, 5'd0, 2'd1, 3'd0), 0);
    send(1, mk_addr(6'd3, 5'd0, 2'd2, 3'd0), 0);
    expect_issue(1, 0, 2'd2, 6'd3, 5'd0, 3'd0, "R4 ll first");
    expect_issue(0, 0, 2'd0, 6'd1, 5'd0, 3'd0, "R4 R9 st bank0 after bank2");
    expect_issue(0, 0, 2'd1, 6'd2, 5'd0, 3'd0, "R4 st bank1");
    drain();

    // R7: direction continuation
    do_reset();
    send(0, mk_addr(6'd1, 5'd0, 2'd0, 3'd0), 1);
    send(0, mk_addr(6'd2, 5'd0, 2'd1, 3'd0), 0);
    send(0, mk_addr(6'd3, 5'd0, 2'd2, 3'd0), 1);
    send(0, mk_addr(6'd4, 5'd0, 2'd3, 3'd0), 0);
    expect_issue(0, 0, 2'd1, 6'd2, 5'd0, 3'd0, "R7 R10 read first");
    expect_issue(0, 0, 2'd3, 6'd4, 5'd0, 3'd0, "R7 read run continues");
    expect_issue(0, 1, 2'd0, 6'd1, 5'd0, 3'd0, "R7 turn to writes");
    expect_issue(0, 1, 2'd2, 6'd3, 5'd0, 3'd0, "R7 write run continues");
    drain();

    // R8: run limit forces a turnaround
    do_reset();
    send(0, mk_addr(6'd10, 5'd0, 2'd0, 3'd0), 0);
    send(0, mk_addr(6'd11, 5'd0, 2'd0, 3'd0), 0);
    send(0, mk_addr(6'd12, 5'd0, 2'd1, 3'd0), 0);
    send(0, mk_addr(6'd13, 5'd0, 2'd1, 3'd0), 0);
    send(0, mk_addr(6'd14, 5'd0, 2'd2, 3'd0), 1);
    expect_issue(0, 0, 2'd0, 6'd10, 5'd0, 3'd0, "R8 read 1");
    expect_issue(0, 0, 2'd1, 6'd12, 5'd0, 3'd0, "R8 read 2");
    expect_issue(0, 0, 2'd0, 6'd11, 5'd0, 3'd0, "R8 R11 read 3");
    expect_issue(0, 1, 2'd2, 6'd14, 5'd0, 3'd0, "R8 write after run limit");
    expect_issue(0, 0, 2'd1, 6'd13, 5'd0, 3'd0, "R8 remaining read");
    drain();

    // R6: busy bank skipped
    do_reset();
    bank_busy = 4'b0001;
    send(0, mk_addr(6'd20, 5'd0, 2'd0, 3'd0), 0);
    send(0, mk_addr(6'd21, 5'd0, 2'd1, 3'd0), 0);
    expect_issue(0, 0, 2'd1, 6'd21, 5'd0, 3'd0, "R6 free bank issued");
    drain();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(iss_valid == 0, "R6 no offer while only busy bank pending", iss_valid, 0);
      step();
    end
    bank_busy = '0;
    expect_issue(0, 0, 2'd0, 6'd20, 5'd0, 3'd0, "R6 bank0 after release");
    drain();

    // R5: sliding-window limit on low-latency issues
    do_reset();
    send(1, mk_addr(6'd30, 5'd0, 2'd0, 3'd0), 0);
    send(1, mk_addr(6'd31, 5'd0, 2'd1, 3'd0), 0);
    send(1, mk_addr(6'd32, 5'd0, 2'd2, 3'd0), 0);
    send(0, mk_addr(6'd33, 5'd0, 2'd3, 3'd0), 0);
    expect_issue(1, 0, 2'd0, 6'd30, 5'd0, 3'd0, "R5 ll 1");
    expect_issue(1, 0, 2'd1, 6'd31, 5'd0, 3'd0, "R5 ll 2");
    expect_issue(0, 0, 2'd3, 6'd33, 5'd0, 3'd0, "R5 st while ll held");
    expect_issue(1, 0, 2'd2, 6'd32, 5'd0, 3'd0, "R5 held ll keeps its class");
    drain();
    check(ll_cyc.size() == 3, "R5 low-latency issue count", ll_cyc.size(), 3);
    if (ll_cyc.size() == 3) begin
      check(ll_cyc[1] - ll_cyc[0] == 1, "R5 second ll spacing", ll_cyc[1] - ll_cyc[0], 1);
      check(ll_cyc[2] - ll_cyc[0] == 8, "R5 third ll waits for window", ll_cyc[2] - ll_cyc[0], 8);
    end

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule